// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Sequencer

This block sits beside the instruction sequencer of a small 8-bit controller core. It handles two interrupt sources. One is a host write that fills the input buffer. The other is an overflow of the on-chip timer.

It does the following:
- keeps one enable bit per source and latches each request strobe as pending;
- at an instruction boundary, picks one enabled pending source by fixed priority and reports the fixed vector address that fetch must jump to;
- pushes the return context onto an eight-entry hardware stack, and does the same for ordinary subroutine calls.

Two return commands pop that stack. The plain return gives back only the program counter. The restoring return also gives back the upper status nibble and re-opens interrupt acceptance. The current stack pointer is output so that the status word can hold it in its low three bits.

Top module: `irq_seq`

## Requirements
- R1: While reset is held and at the first cycle after it:
  - `vec_o` is 0x000;
  - `take_o`, `push_o`, `ret_o` and `in_svc_o` are 0;
  - `sp_o` is 0;
  - both enables are off, nothing is pending, and all stack entries are zero.
- R2: When an interrupt is taken at a clock edge, `take_o` is 1 for the cycle after that edge, and `vec_o` shows the vector in that same cycle:
  - 0x003 for the input-buffer source;
  - 0x007 for the timer source.
- R3: When both sources are pending and enabled at a boundary, the input-buffer source is taken and the timer request stays pending.
- R4: Each source has its own enable command and its own disable command.
  - If both arrive in the same cycle, disable wins.
  - A request that arrives while its source is disabled stays pending. It is taken at a later boundary once the source is enabled.
- R5: Taking an interrupt clears the pending bit of the serviced source only. A strobe of that source in the same cycle latches it again.
- R6: After a take, `in_svc_o` is 1 and no further interrupt is taken until a restoring return clears it. A request still pending at that point is taken at the next eligible boundary.
- R7: A take happens only at an edge where `insn_bound_i` is 1 and no call or return command is present.
- R8: A call or a take writes the 16-bit entry {`psw_hi_i`, `ret_pc_i`} at the slot `sp_o` points to, then increments `sp_o`.
  - In the entry, bits 15:12 are the status nibble and bits 11:0 are the PC.
  - `push_o` pulses for one cycle, and `push_data_o` carries the entry.
- R9: A plain return decrements `sp_o` and places the PC of the entry at the new pointer on `ret_pc_o`.
  - `ret_o` pulses for one cycle and `ret_psw_load_o` is 0.
  - `in_svc_o` is left unchanged.
- R10: A restoring return does everything a plain return does. It also places bits 15:12 of the entry on `ret_psw_o`, sets `ret_psw_load_o` to 1 and clears `in_svc_o`.
- R11: The stack pointer wraps modulo 8 when it moves up past 7 or down past 0. No error is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ibf_req_i | input | 1 | Input-buffer-full event strobe |
| tmr_req_i | input | 1 | Timer overflow event strobe |
| ibf_en_i | input | 1 | Enable input-buffer interrupt |
| ibf_dis_i | input | 1 | Disable input-buffer interrupt |
| tmr_en_i | input | 1 | Enable timer interrupt |
| tmr_dis_i | input | 1 | Disable timer interrupt |
| insn_bound_i | input | 1 | Instruction boundary, an interrupt may be taken |
| call_i | input | 1 | Subroutine call, push context |
| ret_plain_i | input | 1 | Return, pop PC only |
| ret_restore_i | input | 1 | Return, pop PC and status nibble, re-arm interrupts |
| ret_pc_i | input | 12 | PC to be saved on a push |
| psw_hi_i | input | 4 | Status nibble to be saved on a push |
| take_o | output | 1 | Interrupt taken, jump to `vec_o` |
| vec_o | output | 12 | Vector address |
| in_svc_o | output | 1 | An interrupt is in service |
| sp_o | output | 3 | Stack pointer |
| push_o | output | 1 | Stack entry written |
| push_data_o | output | 16 | Entry written |
| ret_o | output | 1 | Stack entry read |
| ret_pc_o | output | 12 | PC popped |
| ret_psw_o | output | 4 | Status nibble popped |
| ret_psw_load_o | output | 1 | Status nibble must be loaded |

## Verification
The bench builds the block with its defaults:
- 12-bit PC;
- 4-bit status nibble;
- depth of eight, so the pointer is three bits wide.

With eight slots, a few thousand random cycles of calls and returns push the pointer past both ends many times, so wrap-around and reads of overwritten slots are exercised routinely. The short vectors 0x003 and 0x007 in a 12-bit field make a source mix-up visible at once. Directed sequences cover simultaneous requests, requests arriving while disabled, same-cycle enable and disable, and boundaries that coincide with a call.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int PC_W    = 12,
  parameter int PSW_W   = 4,
  parameter int DEPTH   = 8,
  parameter int IBF_VEC = 3,
  parameter int TMR_VEC = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ibf_req_i,
  input  logic                       tmr_req_i,
  input  logic                       ibf_en_i,
  input  logic                       ibf_dis_i,
  input  logic                       tmr_en_i,
  input  logic                       tmr_dis_i,
  input  logic                       insn_bound_i,
  input  logic                       call_i,
  input  logic                       ret_plain_i,
  input  logic                       ret_restore_i,
  input  logic [PC_W-1:0]            ret_pc_i,
  input  logic [PSW_W-1:0]           psw_hi_i,
  output logic                       take_o,
  output logic [PC_W-1:0]            vec_o,
  output logic                       in_svc_o,
  output logic [$clog2(DEPTH)-1:0]   sp_o,
  output logic                       push_o,
  output logic [PC_W+PSW_W-1:0]      push_data_o,
  output logic                       ret_o,
  output logic [PC_W-1:0]            ret_pc_o,
  output logic [PSW_W-1:0]           ret_psw_o,
  output logic                       ret_psw_load_o
);
  localparam int SPW = $clog2(DEPTH);
  localparam int EW  = PC_W + PSW_W;

  logic en_i, en_t, pend_i, pend_t, svc;
  logic [SPW-1:0] sp;
  logic [EW-1:0]  stk [DEPTH];

  wire fire_i = pend_i & en_i;
  wire fire_t = pend_t & en_t;
  wire quiet  = ~call_i & ~ret_plain_i & ~ret_restore_i;
  wire take   = insn_bound_i & ~svc & quiet & (fire_i | fire_t);
  wire push   = take | call_i;
  wire pop    = ret_plain_i | ret_restore_i;
  wire [SPW-1:0] sp_dn = sp - 1'b1;
  wire [EW-1:0]  entry = {psw_hi_i, ret_pc_i};

  assign in_svc_o = svc;
  assign sp_o     = sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_i <= 1'b0; en_t <= 1'b0; pend_i <= 1'b0; pend_t <= 1'b0;
      svc <= 1'b0; sp <= '0;
      take_o <= 1'b0; vec_o <= '0; push_o <= 1'b0; push_data_o <= '0;
      ret_o <= 1'b0; ret_pc_o <= '0; ret_psw_o <= '0; ret_psw_load_o <= 1'b0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
    end else begin
      en_i   <= ibf_dis_i ? 1'b0 : (ibf_en_i ? 1'b1 : en_i);
      en_t   <= tmr_dis_i ? 1'b0 : (tmr_en_i ? 1'b1 : en_t);
      pend_i <= ibf_req_i | (pend_i & ~(take & fire_i));
      pend_t <= tmr_req_i | (pend_t & ~(take & ~fire_i));
      svc    <= take ? 1'b1 : (ret_restore_i ? 1'b0 : svc);
      take_o <= take;
      if (take) vec_o <= fire_i ? PC_W'(IBF_VEC) : PC_W'(TMR_VEC);
      push_o <= push;
      ret_o  <= pop & ~push;
      if (push) begin
        stk[sp]     <= entry;
        push_data_o <= entry;
        sp          <= sp + 1'b1;
      end else if (pop) begin
        sp             <= sp_dn;
        ret_pc_o       <= stk[sp_dn][PC_W-1:0];
        ret_psw_o      <= stk[sp_dn][EW-1:PC_W];
        ret_psw_load_o <= ret_restore_i;
      end
    end
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int PC_W    = 12,
  parameter int SPW     = 3,
  parameter int IBF_VEC = 3,
  parameter int TMR_VEC = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ibf_req_i,
  input logic            ret_restore_i,
  input logic            take_o,
  input logic [PC_W-1:0] vec_o,
  input logic            in_svc_o,
  input logic [SPW-1:0]  sp_o,
  input logic            push_o,
  input logic            ret_o,
  input logic            ret_psw_load_o,
  input logic            pend_i,
  input logic            en_i
);
  p_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_o == PC_W'(IBF_VEC) || vec_o == PC_W'(TMR_VEC)));
  p_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == PC_W'(TMR_VEC)) |-> !$past(pend_i && en_i));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == PC_W'(IBF_VEC) && !$past(ibf_req_i)) |-> !pend_i);
  p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_o && !ret_restore_i) |=> !take_o);
  p_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (push_o && in_svc_o));
  p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> sp_o == SPW'($past(sp_o) + 1'b1));
  p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_o && ret_psw_load_o) |-> !in_svc_o);
endmodule

bind irq_seq irq_seq_chk #(
  .PC_W(PC_W), .SPW($clog2(DEPTH)), .IBF_VEC(IBF_VEC), .TMR_VEC(TMR_VEC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ibf_req_i(ibf_req_i), .ret_restore_i(ret_restore_i),
  .take_o(take_o), .vec_o(vec_o), .in_svc_o(in_svc_o), .sp_o(sp_o),
  .push_o(push_o), .ret_o(ret_o), .ret_psw_load_o(ret_psw_load_o),
  .pend_i(pend_i), .en_i(en_i)
);

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] M_IBF = 10'd1,   M_TMR = 10'd2,   M_EI  = 10'd4,
                         M_DI  = 10'd8,   M_ET  = 10'd16,  M_DT  = 10'd32,
                         M_BND = 10'd64,  M_CALL = 10'd128, M_RP = 10'd256,
                         M_RR  = 10'd512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] stim = '0;
  logic [11:0] rpc = '0;
  logic [3:0] psw = '0;
  logic take, in_svc, push, ret, rload;
  logic [11:0] vec, r_pc;
  logic [2:0] sp;
  logic [15:0] pdata;
  logic [3:0] r_psw;
  int errors = 0, checks = 0;
  bit comparing = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .ibf_req_i(stim[0]), .tmr_req_i(stim[1]), .ibf_en_i(stim[2]), .ibf_dis_i(stim[3]),
    .tmr_en_i(stim[4]), .tmr_dis_i(stim[5]), .insn_bound_i(stim[6]), .call_i(stim[7]),
    .ret_plain_i(stim[8]), .ret_restore_i(stim[9]), .ret_pc_i(rpc), .psw_hi_i(psw),
    .take_o(take), .vec_o(vec), .in_svc_o(in_svc), .sp_o(sp), .push_o(push),
    .push_data_o(pdata), .ret_o(ret), .ret_pc_o(r_pc), .ret_psw_o(r_psw),
    .ret_psw_load_o(rload)
  );

  // expected-value model built from the requirements
  logic m_ei, m_et, m_pi, m_pt, m_svc, m_take, m_push, m_ret, m_rload;
  logic [2:0] m_sp;
  logic [11:0] m_vec, m_rpc;
  logic [3:0] m_rpsw;
  logic [15:0] m_pdata;
  logic [15:0] m_stk [8];

  function automatic logic [11:0] vec_of(input logic ibf_wins);
    return ibf_wins ? 12'h003 : 12'h007;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ei = 0; m_et = 0; m_pi = 0; m_pt = 0; m_svc = 0; m_take = 0; m_push = 0;
      m_ret = 0; m_rload = 0; m_sp = 0; m_vec = 0; m_rpc = 0; m_rpsw = 0; m_pdata = 0;
      for (int k = 0; k < 8; k++) m_stk[k] = 0;
    end else begin
      logic fi, ft, tk, pu, po;
      fi = m_pi & m_ei;
      ft = m_pt & m_et;
      tk = stim[6] & !m_svc & !(stim[7] | stim[8] | stim[9]) & (fi | ft);
      pu = tk | stim[7];
      po = stim[8] | stim[9];
      m_pi = stim[0] | (m_pi & !(tk & fi));
      m_pt = stim[1] | (m_pt & !(tk & !fi));
      m_ei = stim[3] ? 1'b0 : (stim[2] ? 1'b1 : m_ei);
      m_et = stim[5] ? 1'b0 : (stim[4] ? 1'b1 : m_et);
      m_take = tk;
      if (tk) m_vec = vec_of(fi);
      m_push = pu;
      m_ret = po & !pu;
      if (pu) begin
        m_pdata = {psw, rpc};
        m_stk[m_sp] = m_pdata;
        m_sp = m_sp + 3'd1;
      end else if (po) begin
        m_sp = m_sp - 3'd1;
        m_rpc = m_stk[m_sp][11:0];
        m_rpsw = m_stk[m_sp][15:12];
        m_rload = stim[9];
      end
      if (tk) m_svc = 1;
      else if (stim[9]) m_svc = 0;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (comparing) begin
    check("R2 take", 16'(take), 16'(m_take));
    check("R2 vector", 16'(vec), 16'(m_vec));
    check("R6 in_svc", 16'(in_svc), 16'(m_svc));
    check("R11 sp", 16'(sp), 16'(m_sp));
    check("R8 push", 16'(push), 16'(m_push));
    if (push) check("R8 data", pdata, m_pdata);
    check("R9 ret", 16'(ret), 16'(m_ret));
    if (ret) begin
      check("R9 pc", 16'(r_pc), 16'(m_rpc));
      check("R10 load", 16'(rload), 16'(m_rload));
      if (rload) check("R10 psw", 16'(r_psw), 16'(m_rpsw));
    end
  end

  task automatic drive(input logic [9:0] s);
    stim = s;
    rpc = 12'($urandom);
    psw = 4'($urandom);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0] sp0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 vec", 16'(vec), 16'h000);
    check("R1 in_svc", 16'(in_svc), 16'd0);
    rst_n = 1;
    @(negedge clk);
    comparing = 1;
    check("R1 sp", 16'(sp), 16'd0);
    check("R1 take", 16'(take), 16'd0);
    drive(M_IBF | M_TMR | M_BND);
    check("R4 disabled no take", 16'(take), 16'd0);
    drive(M_EI | M_ET);
    drive(M_BND);
    check("R3 priority", 16'(vec), 16'h003);
    check("R3 take", 16'(take), 16'd1);
    drive(M_BND);
    check("R6 blocked", 16'(take), 16'd0);
    drive(M_RR);
    check("R10 rearm", 16'(in_svc), 16'd0);
    drive(M_CALL | M_BND);
    check("R7 no take with call", 16'(take), 16'd0);
    drive(M_BND);
    check("R6 held timer taken", 16'(vec), 16'h007);
    check("R6 take", 16'(take), 16'd1);
    drive(M_RR);
    drive(M_BND);
    check("R5 pending cleared", 16'(take), 16'd0);
    drive(M_TMR | M_ET | M_DT);
    drive(M_BND);
    check("R4 disable wins", 16'(take), 16'd0);
    sp0 = sp;
    for (int k = 0; k < 8; k++) drive(M_CALL);
    check("R11 wrap up", 16'(sp), 16'(sp0));
    for (int k = 0; k < 9; k++) drive(M_RP);
    check("R11 wrap down", 16'(sp), 16'(sp0 - 3'd1));
    for (int n = 0; n < 4000; n++) begin
      logic [9:0] s;
      int r;
      s = '0;
      if ($urandom % 6 == 0) s |= M_IBF;
      if ($urandom % 6 == 0) s |= M_TMR;
      if ($urandom % 10 == 0) s |= M_EI;
      if ($urandom % 30 == 0) s |= M_DI;
      if ($urandom % 10 == 0) s |= M_ET;
      if ($urandom % 30 == 0) s |= M_DT;
      if ($urandom % 2 == 0) s |= M_BND;
      r = int'($urandom % 12);
      if (r == 0) s |= M_CALL;
      else if (r == 1) s |= M_RP;
      else if (r == 2 || r == 3) s |= M_RR;
      drive(s);
    end
    drive('0);
    comparing = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule